// File: doc/BRIEF.md
# Stop Mode Sequencer

This block decides what a stop request from the processor turns into. Software sets three control bits first: a stop permission bit, a power-down select bit and a partial power-down select bit. Each of them can be written only once between resets. When the processor then raises a stop request, the block either forces a reset (stop not permitted) or parks the chip in one of three stop depths. Stop1 switches the regulator off and loses all state. Stop2 keeps the regulator in loose regulation and latches the pins. Stop3 keeps all state and can be left by any enabled interrupt. Low-voltage detection kept active in stop, or an enabled debug link, quietly turns a deep request into stop3.

Leaving stop1 or stop2 takes a regulator settling time, given in cycles on an input. After it, the block gives a reset handshake together with a one-cycle wake pulse that carries the cause. A stop2 exit also leaves a sticky flag set and the pins still latched. Both stay that way until software writes the acknowledge bit. Leaving stop3 by an interrupt resumes at once with no reset, and the configuration is kept.

Top module: `stopmode_ctl`

## Requirements
- R1: A stop request in run mode while the stop permission bit is clear gives `reset_req` high for exactly one cycle, starting the cycle after the request. `mode` stays 0 (run), and the stop control bits return to their reset values.
- R2: The stop permission bit locks at the first `cfg_we` after reset. The two select bits lock together at the first `pm_we` after reset. Later writes leave them unchanged until the next reset or stop1/stop2 exit.
- R3: `mode` encodes the state as 0 run, 1 stop1, 2 stop2, 3 stop3, and changes the cycle after the request. With the forcing inputs low, power-down set and partial clear selects 1, both set selects 2, and power-down clear selects 3 whatever the partial bit holds.
- R4: When `lvd_stop_en` or `dbg_en` is high at the request, the block enters stop3 whatever the select bits hold. `dbg_clk_on` is high in run mode, and high in stop3 only if `dbg_en` was high at entry.
- R5: In stop1, `reg_off` is high and `io_hold` is low. Only a falling edge on `irq_n` or `ext_rst` starts an exit; `rti_evt`, `kbi_evt` and `lvd_evt` have no effect.
- R6: In stop2, `reg_loose` and `io_hold` are high. `irq_n` falling, `ext_rst` or `rti_evt` start an exit; `kbi_evt` and `lvd_evt` have no effect.
- R7: A stop1/stop2 exit holds the stop mode for `recov_cycles`+1 cycles after the edge that samples the wake event. On the next edge, `mode` returns to 0, `wake_pulse` and `reset_req` are high together for one cycle, and all stop control bits are cleared.
- R8: A stop2 exit sets `ppd_flag`; a stop1 exit clears it. While `ppd_flag` is set, `io_hold` stays high until a `pm_we` with `pm_ack`=1 in run mode, which clears both on the next edge.
- R9: In stop3, any of `irq_n` falling, `kbi_evt`, `rti_evt` or `lvd_evt` returns `mode` to 0 on the next edge, with a one-cycle `wake_pulse` and no `reset_req`. The control bits are kept.
- R10: `ext_rst` in stop3 gives `wake_pulse` and `reset_req` on the next edge and clears the control bits. In run mode it gives `reset_req`, clears the control bits and clears `ppd_flag`.
- R11: `wake_cause` is valid with `wake_pulse`, coded 1 IRQ, 2 reset pin, 3 periodic timer, 4 keyboard, 5 low-voltage. When several sources fire in one cycle, the order is reset pin, IRQ, timer, keyboard, low-voltage.
- R12: A stop request while not in run mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| recov_cycles | input | RECOV_W | Regulator settling delay in cycles |
| cfg_we | input | 1 | Write strobe for the stop permission bit |
| cfg_stop_en | input | 1 | Stop permission write data |
| pm_we | input | 1 | Write strobe for select bits and acknowledge |
| pm_pdc | input | 1 | Power-down select write data |
| pm_ppdc | input | 1 | Partial power-down select write data |
| pm_ack | input | 1 | Acknowledge of stop2 recovery |
| stop_req | input | 1 | Stop request from the processor |
| lvd_stop_en | input | 1 | Low-voltage detection kept active in stop |
| dbg_en | input | 1 | Debug link enabled |
| irq_n | input | 1 | External interrupt pin, falling edge wakes |
| ext_rst | input | 1 | Reset pin asserted (synchronous) |
| rti_evt | input | 1 | Periodic timer event |
| kbi_evt | input | 1 | Keyboard event |
| lvd_evt | input | 1 | Low-voltage event |
| mode | output | 2 | Current mode |
| reg_off | output | 1 | Regulator off |
| reg_loose | output | 1 | Regulator in loose regulation |
| io_hold | output | 1 | Pin states latched |
| dbg_clk_on | output | 1 | Debug logic clock running |
| reset_req | output | 1 | One-cycle reset request |
| wake_pulse | output | 1 | One-cycle stop exit indication |
| wake_cause | output | 3 | Exit cause, valid with wake_pulse |
| ppd_flag | output | 1 | Sticky stop2 recovery flag |

## Verification
A stuck control bit shows up on the next stop request. Either the chosen stop depth on `mode` is wrong, or a permitted stop turns into a `reset_req`, one cycle after the request. A recovery counter that is off by one moves `wake_pulse` one cycle early or late against the `recov_cycles`+2 edge budget. A wrongly encoded source mask shows as an exit from stop1 or stop2 on an event that should be ignored, or a wrong `wake_cause`. A flag that is not sticky drops `io_hold` before the acknowledge write.

// File: rtl/stopmode_ctl.sv
module stopmode_ctl #(
  parameter int RECOV_W = 8
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [RECOV_W-1:0] recov_cycles,
  input  logic               cfg_we,
  input  logic               cfg_stop_en,
  input  logic               pm_we,
  input  logic               pm_pdc,
  input  logic               pm_ppdc,
  input  logic               pm_ack,
  input  logic               stop_req,
  input  logic               lvd_stop_en,
  input  logic               dbg_en,
  input  logic               irq_n,
  input  logic               ext_rst,
  input  logic               rti_evt,
  input  logic               kbi_evt,
  input  logic               lvd_evt,
  output logic [1:0]         mode,
  output logic               reg_off,
  output logic               reg_loose,
  output logic               io_hold,
  output logic               dbg_clk_on,
  output logic               reset_req,
  output logic               wake_pulse,
  output logic [2:0]         wake_cause,
  output logic               ppd_flag
);
  localparam logic [1:0] RUN = 2'd0, S1 = 2'd1, S2 = 2'd2, S3 = 2'd3;
  localparam logic [2:0] C_NONE = 3'd0, C_IRQ = 3'd1, C_RST = 3'd2,
                         C_RTI = 3'd3, C_KBI = 3'd4, C_LVD = 3'd5;

  logic [1:0]         mode_q;
  logic               recov_q;
  logic [RECOV_W-1:0] cnt_q;
  logic [2:0]         pend_q, cause_q, ev_cause;
  logic               stop_en_q, sopt_lk_q, pdc_q, ppdc_q, pm_lk_q;
  logic               flag_q, irq_q, dbg_keep_q, wake_q, rstreq_q;
  logic [1:0]         sel_mode;
  logic               irq_fall, release_w, illegal, clr, in_run, full_rst;

  assign in_run    = (mode_q == RUN);
  assign irq_fall  = irq_q & ~irq_n;
  assign release_w = recov_q && (cnt_q == '0);
  assign illegal   = in_run && !ext_rst && stop_req && !stop_en_q;
  assign full_rst  = ext_rst && (in_run || mode_q == S3);
  assign clr       = release_w || full_rst || illegal;
  assign sel_mode  = (!pdc_q || lvd_stop_en || dbg_en) ? S3 : (ppdc_q ? S2 : S1);

  always_comb begin
    ev_cause = C_NONE;
    if (ext_rst)                          ev_cause = C_RST;
    else if (irq_fall)                    ev_cause = C_IRQ;
    else if (rti_evt && mode_q != S1)     ev_cause = C_RTI;
    else if (kbi_evt && mode_q == S3)     ev_cause = C_KBI;
    else if (lvd_evt && mode_q == S3)     ev_cause = C_LVD;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      {stop_en_q, sopt_lk_q, pdc_q, ppdc_q, pm_lk_q} <= '0;
    end else if (clr) begin
      {stop_en_q, sopt_lk_q, pdc_q, ppdc_q, pm_lk_q} <= '0;
    end else if (in_run) begin
      if (cfg_we && !sopt_lk_q) begin
        stop_en_q <= cfg_stop_en;
        sopt_lk_q <= 1'b1;
      end
      if (pm_we && !pm_lk_q) begin
        pdc_q   <= pm_pdc;
        ppdc_q  <= pm_ppdc;
        pm_lk_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          flag_q <= 1'b0;
    else if (release_w)                  flag_q <= (mode_q == S2);
    else if (full_rst)                   flag_q <= 1'b0;
    else if (in_run && pm_we && pm_ack)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q     <= RUN;
      recov_q    <= 1'b0;
      cnt_q      <= '0;
      pend_q     <= C_NONE;
      cause_q    <= C_NONE;
      irq_q      <= 1'b1;
      dbg_keep_q <= 1'b0;
      wake_q     <= 1'b0;
      rstreq_q   <= 1'b0;
    end else begin
      irq_q    <= irq_n;
      wake_q   <= 1'b0;
      rstreq_q <= 1'b0;
      cause_q  <= C_NONE;
      if (in_run) begin
        if (ext_rst || illegal) begin
          rstreq_q <= 1'b1;
        end else if (stop_req) begin
          mode_q     <= sel_mode;
          dbg_keep_q <= dbg_en && (sel_mode == S3);
        end
      end else if (recov_q) begin
        if (release_w) begin
          mode_q   <= RUN;
          recov_q  <= 1'b0;
          wake_q   <= 1'b1;
          rstreq_q <= 1'b1;
          cause_q  <= pend_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (ev_cause != C_NONE) begin
        if (mode_q == S3) begin
          mode_q     <= RUN;
          wake_q     <= 1'b1;
          rstreq_q   <= (ev_cause == C_RST);
          cause_q    <= ev_cause;
          dbg_keep_q <= 1'b0;
        end else begin
          recov_q <= 1'b1;
          cnt_q   <= recov_cycles;
          pend_q  <= ev_cause;
        end
      end
    end
  end

  assign mode       = mode_q;
  assign reg_off    = (mode_q == S1) && !recov_q;
  assign reg_loose  = ((mode_q == S2) && !recov_q) || (mode_q == S3);
  assign io_hold    = (mode_q == S2) || (mode_q == S3) || flag_q;
  assign dbg_clk_on = in_run || dbg_keep_q;
  assign reset_req  = rstreq_q;
  assign wake_pulse = wake_q;
  assign wake_cause = cause_q;
  assign ppd_flag   = flag_q;
endmodule

// File: rtl/stopmode_ctl_chk.sv
module stopmode_ctl_chk #(
  parameter int RW = 8
) (
  input logic          clk,
  input logic          por_n,
  input logic          stop_req,
  input logic          ext_rst,
  input logic          pm_we,
  input logic          pm_ack,
  input logic          kbi_evt,
  input logic          rti_evt,
  input logic          lvd_evt,
  input logic [1:0]    mode,
  input logic          reg_off,
  input logic          reg_loose,
  input logic          io_hold,
  input logic          reset_req,
  input logic          wake_pulse,
  input logic [2:0]    wake_cause,
  input logic          ppd_flag,
  input logic          recov_q,
  input logic [RW-1:0] cnt_q,
  input logic          stop_en_q
);
  assert_illegal_reset_R1: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'd0 && !ext_rst && stop_req && !stop_en_q) |=> (reset_req && mode == 2'd0));

  assert_stop1_rails_R5: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'd1 && !recov_q) |-> (reg_off && !reg_loose && !io_hold));

  assert_stop2_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'd2) |-> (io_hold && !reg_off));

  assert_release_R7: assert property (@(posedge clk) disable iff (!por_n)
    (recov_q && cnt_q == '0) |=> (wake_pulse && reset_req && mode == 2'd0));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!por_n)
    wake_pulse |=> !wake_pulse);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
    (ppd_flag && mode == 2'd0 && !ext_rst && !(pm_we && pm_ack)) |=> ppd_flag);

  assert_s3_resume_R9: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'd3 && !ext_rst && (kbi_evt || rti_evt || lvd_evt)) |=>
      (wake_pulse && !reset_req && mode == 2'd0));

  assert_s3_reset_R10: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'd3 && ext_rst) |=> (wake_pulse && reset_req && wake_cause == 3'd2));

  assert_cause_range_R11: assert property (@(posedge clk) disable iff (!por_n)
    wake_pulse |-> (wake_cause >= 3'd1 && wake_cause <= 3'd5));
endmodule

bind stopmode_ctl stopmode_ctl_chk #(.RW(RECOV_W)) chk_i (
  .clk(clk), .por_n(por_n), .stop_req(stop_req), .ext_rst(ext_rst),
  .pm_we(pm_we), .pm_ack(pm_ack), .kbi_evt(kbi_evt), .rti_evt(rti_evt),
  .lvd_evt(lvd_evt), .mode(mode), .reg_off(reg_off), .reg_loose(reg_loose),
  .io_hold(io_hold), .reset_req(reset_req), .wake_pulse(wake_pulse),
  .wake_cause(wake_cause), .ppd_flag(ppd_flag), .recov_q(recov_q),
  .cnt_q(cnt_q), .stop_en_q(stop_en_q)
);

// File: tb/stopmode_ctl_tb_top.sv
`timescale 1ns/1ps
module stopmode_ctl_tb_top;
  localparam int RW = 8;
  localparam int NREC = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic [RW-1:0] recov_cycles = RW'(NREC);
  logic cfg_we = 0, cfg_stop_en = 0, pm_we = 0, pm_pdc = 0, pm_ppdc = 0, pm_ack = 0;
  logic stop_req = 0, lvd_stop_en = 0, dbg_en = 0, irq_n = 1, ext_rst = 0;
  logic rti_evt = 0, kbi_evt = 0, lvd_evt = 0;
  logic [1:0] mode;
  logic reg_off, reg_loose, io_hold, dbg_clk_on, reset_req, wake_pulse, ppd_flag;
  logic [2:0] wake_cause;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stopmode_ctl #(.RECOV_W(RW)) dut_i (
    .clk(clk), .por_n(por_n), .recov_cycles(recov_cycles),
    .cfg_we(cfg_we), .cfg_stop_en(cfg_stop_en), .pm_we(pm_we), .pm_pdc(pm_pdc),
    .pm_ppdc(pm_ppdc), .pm_ack(pm_ack), .stop_req(stop_req),
    .lvd_stop_en(lvd_stop_en), .dbg_en(dbg_en), .irq_n(irq_n), .ext_rst(ext_rst),
    .rti_evt(rti_evt), .kbi_evt(kbi_evt), .lvd_evt(lvd_evt), .mode(mode),
    .reg_off(reg_off), .reg_loose(reg_loose), .io_hold(io_hold),
    .dbg_clk_on(dbg_clk_on), .reset_req(reset_req), .wake_pulse(wake_pulse),
    .wake_cause(wake_cause), .ppd_flag(ppd_flag)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_sopt(input logic b);
    cfg_we = 1; cfg_stop_en = b; tick(); cfg_we = 0;
  endtask

  task automatic wr_pm(input logic pdc, input logic ppdc, input logic ack);
    pm_we = 1; pm_pdc = pdc; pm_ppdc = ppdc; pm_ack = ack; tick();
    pm_we = 0; pm_ack = 0;
  endtask

  task automatic pin_rst();
    ext_rst = 1; tick(); ext_rst = 0; tick();
  endtask

  task automatic do_stop();
    stop_req = 1; tick(); stop_req = 0;
  endtask

  task automatic await_release(input string tag, input int cause);
    repeat (NREC) tick();
    chk({tag, " no early wake"}, wake_pulse, 0);
    tick();
    chk({tag, " wake"}, wake_pulse, 1);
    chk({tag, " reset_req"}, reset_req, 1);
    chk({tag, " cause"}, wake_cause, cause);
    chk({tag, " mode run"}, mode, 0);
  endtask

  task automatic t_reset();
    chk("R3 reset mode", mode, 0);
    chk("R10 reset reset_req", reset_req, 0);
    chk("R8 reset flag", ppd_flag, 0);
    chk("R4 reset dbg clock", dbg_clk_on, 1);
    chk("R5 reset io_hold", io_hold, 0);
  endtask

  task automatic t_illegal_R1();
    do_stop();
    chk("R1 illegal reset_req", reset_req, 1);
    chk("R1 illegal mode", mode, 0);
    tick();
    chk("R1 reset_req one cycle", reset_req, 0);
  endtask

  task automatic t_write_once_R2();
    wr_sopt(1); wr_sopt(0);
    wr_pm(1, 0, 0); wr_pm(0, 1, 0);
    do_stop();
    chk("R2 locked bits give stop1", mode, 1);
    chk("R3 stop1 selected", mode, 1);
  endtask

  task automatic t_stop1_R5();
    chk("R5 regulator off", reg_off, 1);
    chk("R5 pins not held", io_hold, 0);
    rti_evt = 1; tick(); rti_evt = 0;
    kbi_evt = 1; tick(); kbi_evt = 0;
    lvd_evt = 1; tick(); lvd_evt = 0;
    tick();
    chk("R5 ignored events mode", mode, 1);
    chk("R5 ignored events wake", wake_pulse, 0);
    irq_n = 0; tick();
    await_release("R7 stop1", 1);
    chk("R8 no flag after stop1", ppd_flag, 0);
    irq_n = 1; tick();
    chk("R7 pulse one cycle", wake_pulse, 0);
    do_stop();
    chk("R7 config cleared after exit", reset_req, 1);
  endtask

  task automatic t_stop2_R6();
    tick();
    wr_sopt(1); wr_pm(1, 1, 0);
    do_stop();
    chk("R6 stop2 mode", mode, 2);
    chk("R6 loose regulation", reg_loose, 1);
    chk("R6 pins held", io_hold, 1);
    kbi_evt = 1; lvd_evt = 1; tick(); kbi_evt = 0; lvd_evt = 0;
    tick();
    chk("R6 kbi/lvd ignored", mode, 2);
    rti_evt = 1; tick(); rti_evt = 0;
    await_release("R7 stop2", 3);
    chk("R8 flag set", ppd_flag, 1);
    chk("R8 pins held after wake", io_hold, 1);
  endtask

  task automatic t_ack_R8();
    repeat (4) tick();
    chk("R8 flag sticky", ppd_flag, 1);
    chk("R8 hold sticky", io_hold, 1);
    wr_pm(0, 0, 1);
    chk("R8 flag cleared by ack", ppd_flag, 0);
    chk("R8 hold released", io_hold, 0);
  endtask

  task automatic t_stop3_R9();
    pin_rst();
    wr_sopt(1); wr_pm(0, 1, 0);
    do_stop();
    chk("R3 pdc clear gives stop3", mode, 3);
    stop_req = 1; tick(); stop_req = 0;
    chk("R12 stop_req in stop ignored", mode, 3);
    chk("R12 no reset", reset_req, 0);
    kbi_evt = 1; tick(); kbi_evt = 0;
    chk("R9 kbi wake", wake_pulse, 1);
    chk("R9 no reset", reset_req, 0);
    chk("R11 kbi cause", wake_cause, 4);
    chk("R9 run", mode, 0);
    do_stop();
    chk("R9 config kept", mode, 3);
    rti_evt = 1; kbi_evt = 1; lvd_evt = 1; tick();
    rti_evt = 0; kbi_evt = 0; lvd_evt = 0;
    chk("R11 priority timer first", wake_cause, 3);
    do_stop();
    lvd_evt = 1; tick(); lvd_evt = 0;
    chk("R11 lvd cause", wake_cause, 5);
    do_stop();
    irq_n = 0; ext_rst = 1; tick(); ext_rst = 0; irq_n = 1;
    chk("R10 stop3 reset wake", wake_pulse, 1);
    chk("R10 stop3 reset_req", reset_req, 1);
    chk("R11 reset beats irq", wake_cause, 2);
    tick();
    do_stop();
    chk("R10 config cleared", reset_req, 1);
  endtask

  task automatic t_force_R4();
    tick();
    wr_sopt(1); wr_pm(1, 0, 0);
    lvd_stop_en = 1; do_stop(); lvd_stop_en = 0;
    chk("R4 lvd forces stop3", mode, 3);
    chk("R4 dbg clock off", dbg_clk_on, 0);
    irq_n = 0; tick(); irq_n = 1;
    chk("R11 irq cause", wake_cause, 1);
    dbg_en = 1; do_stop();
    chk("R4 dbg forces stop3", mode, 3);
    chk("R4 dbg clock kept", dbg_clk_on, 1);
    dbg_en = 0;
    rti_evt = 1; tick(); rti_evt = 0;
    chk("R9 rti wake", wake_pulse, 1);
    do_stop();
    chk("R3 stop1 after forcing off", mode, 1);
    ext_rst = 1; tick(); ext_rst = 0;
    await_release("R7 stop1 pin", 2);
  endtask

  initial begin
    repeat (3) tick();
    por_n = 1;
    tick();
    t_reset();
    t_illegal_R1();
    t_write_once_R2();
    t_stop1_R5();
    t_stop2_R6();
    t_ack_R8();
    t_stop3_R9();
    t_force_R4();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule